// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block keeps one free-running 64-bit real-time counter shared by a group of harts. Each hart also has its own 64-bit compare register and a level interrupt output. The counter advances by one on every clock cycle in which the timebase tick-enable input is high. Hart i raises its interrupt while its compare value is at or below the counter, and drops it as soon as that stops being true.

Software reaches every register through a simple single-cycle register bus. The bus carries an address, a size flag (32-bit or 64-bit), write data, a write strobe and registered read data. The counter and each compare register can be accessed as one 64-bit word or as two little-endian 32-bit halves. A 32-bit write merges into the untouched half. A software write to the counter takes effect at once, and every hart's interrupt is re-evaluated against the new count.

Top module: `hart_timer`

## Requirements
- R1: While reset is high and in the cycle after it, the counter reads zero and every interrupt output is low; compare registers come out of reset holding all ones.
- R2: The counter increases by exactly one on each clock edge where `tick_en` is high and no counter write occurs; with `tick_en` low it holds, and a carry crosses from bit 31 into bit 32.
- R3: A counter write in the same cycle as a tick stores the written value; the increment is dropped.
- R4: A 32-bit write (`bus_wide`=0) at offset 0 of a register replaces bits 31:0 with `bus_wdata[31:0]` and keeps bits 63:32; at offset 4 it replaces bits 63:32 with `bus_wdata[31:0]` and keeps bits 31:0.
- R5: A 64-bit write (`bus_wide`=1) at offset 0 replaces the whole register; a 64-bit write at offset 4 changes nothing.
- R6: `bus_rdata` is valid one cycle after the address is presented: a 32-bit read at offset 0 gives bits 31:0 and at offset 4 gives bits 63:32, both zero-extended; a 64-bit read at offset 0 gives all 64 bits.
- R7: Hart i's compare register sits at `CMP_BASE + 8*i`; the counter sits at `CNT_BASE`, with its high half at `CNT_BASE + 4`.
- R8: `irq_o[i]` is high exactly when compare i is unsigned less than or equal to the counter, over all 64 bits; it follows a compare write one cycle after the write edge.
- R9: After any counter write, every hart's interrupt reflects the new count on the very next cycle, all together.
- R10: A read of an unmapped address, of a hart slot at or beyond `N_HARTS`, of an address with bits 1:0 nonzero, or a 64-bit read at offset 4, returns zero; writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick; counter advances when high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data, little-endian |
| bus_rdata | output | 64 | Registered read data |
| irq_o | output | N_HARTS | Per-hart timer interrupt level |

## Verification
The bench sweeps every hart slot and both halves of every register. It mirrors each write in an arithmetic model, so a half-write that clobbers the other half, or a slot decoded at the wrong stride, shows up as a readback mismatch. Compares are placed one below, equal to and one above the count, and also across a 32-bit boundary where the high halves decide. A design that compared only the low half, or used strict less-than, would raise the wrong interrupts. The bench also times the interrupt edge after compare and counter writes, writes the counter while the tick is high, and walks the unmapped window and the misaligned addresses. These catch a missing register stage, an increment that overrides software, and stray decodes that either return data or corrupt a register.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  localparam int MAX_HARTS = 64;
  localparam int WORD_W    = 64;
  localparam int HALF_W    = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_FULL = 2'd3
  } acc_kind_e;

  // Combine new write data with the current register contents.
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] wd,
    input acc_kind_e         kind
  );
    logic [WORD_W-1:0] res;
    unique case (kind)
      ACC_LO:   res = {cur[WORD_W-1:HALF_W], wd[HALF_W-1:0]};
      ACC_HI:   res = {wd[HALF_W-1:0], cur[HALF_W-1:0]};
      ACC_FULL: res = wd;
      default:  res = cur;
    endcase
    return res;
  endfunction

  // Shape a register value for the read bus.
  function automatic logic [WORD_W-1:0] read_view(
    input logic [WORD_W-1:0] val,
    input acc_kind_e         kind
  );
    logic [WORD_W-1:0] res;
    unique case (kind)
      ACC_LO:   res = {{HALF_W{1'b0}}, val[HALF_W-1:0]};
      ACC_HI:   res = {{HALF_W{1'b0}}, val[WORD_W-1:HALF_W]};
      ACC_FULL: res = val;
      default:  res = '0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/ht_decode.sv
module ht_decode
  import hart_timer_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int ADDR_W   = 12,
  parameter int CMP_BASE = 0,
  parameter int CNT_BASE = 'h40,
  parameter int SLOT_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic              cnt_hit,
  output logic              cmp_hit,
  output logic [SLOT_W-1:0] slot,
  output acc_kind_e         kind
);

  localparam int                REL_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_BASE);

  logic [REL_W-1:0] word_idx;
  logic [REL_W-1:0] rel_idx;
  logic             aligned;
  logic             in_cmp;
  logic             in_cnt;
  acc_kind_e        shape;

  assign word_idx = addr[ADDR_W-1:3];
  assign rel_idx  = word_idx - CMP_A[ADDR_W-1:3];
  assign aligned  = (addr[1:0] == 2'b00);

  // 64-bit accesses are only legal at offset 0 of a register.
  always_comb begin
    if (!aligned)        shape = ACC_NONE;
    else if (wide)       shape = addr[2] ? ACC_NONE : ACC_FULL;
    else                 shape = addr[2] ? ACC_HI : ACC_LO;
  end

  assign in_cmp = (word_idx >= CMP_A[ADDR_W-1:3]) && (rel_idx < REL_W'(N_HARTS));
  assign in_cnt = (word_idx == CNT_A[ADDR_W-1:3]);

  assign cmp_hit = in_cmp && (shape != ACC_NONE);
  assign cnt_hit = in_cnt && !in_cmp && (shape != ACC_NONE);
  assign slot    = rel_idx[SLOT_W-1:0];
  assign kind    = (cmp_hit || cnt_hit) ? shape : ACC_NONE;

endmodule

// File: rtl/ht_counter.sv
module ht_counter
  import hart_timer_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  acc_kind_e        wr_kind,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // Software writes take priority over the tick increment.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_kind != ACC_NONE) begin
      cnt_q <= merge_word(cnt_q, wdata, wr_kind);
    end else if (tick_en) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ht_cmp_bank.sv
module ht_cmp_bank
  import hart_timer_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int SLOT_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  acc_kind_e                 wr_kind,
  input  logic [SLOT_W-1:0]         wr_slot,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [WORD_W-1:0]         cnt_i,
  output logic [N_HARTS*WORD_W-1:0] cmp_flat_o,
  output logic [N_HARTS-1:0]        irq_o
);

  for (genvar i = 0; i < N_HARTS; i++) begin : g_hart
    logic [WORD_W-1:0] cmp_q;
    logic              irq_q;
    logic              sel;

    assign sel = (wr_kind != ACC_NONE) && (wr_slot == SLOT_W'(i));

    // Parked at the top of the range so no hart fires before it is set up.
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q <= '1;
      end else if (sel) begin
        cmp_q <= merge_word(cmp_q, wdata, wr_kind);
      end
    end

    // One register stage after the 64-bit magnitude compare.
    always_ff @(posedge clk) begin
      if (rst) begin
        irq_q <= 1'b0;
      end else begin
        irq_q <= (cmp_q <= cnt_i);
      end
    end

    assign cmp_flat_o[i*WORD_W +: WORD_W] = cmp_q;
    assign irq_o[i]                       = irq_q;
  end

endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int N_HARTS  = 4,
  parameter int ADDR_W   = 12,
  parameter int CMP_BASE = 0,
  parameter int CNT_BASE = 'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wide,
  input  logic               bus_we,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  output logic [N_HARTS-1:0] irq_o
);

  localparam int SLOT_W = (N_HARTS > 1) ? $clog2(N_HARTS) : 1;

  if (N_HARTS < 1 || N_HARTS > MAX_HARTS) begin : g_bad_harts
    $error("hart_timer: N_HARTS out of range");
  end
  if ((CMP_BASE % 8) != 0 || (CNT_BASE % 8) != 0) begin : g_bad_align
    $error("hart_timer: register bases must be 8-byte aligned");
  end

  logic                      cnt_hit;
  logic                      cmp_hit;
  logic [SLOT_W-1:0]         slot;
  acc_kind_e                 kind;
  acc_kind_e                 cnt_wk;
  acc_kind_e                 cmp_wk;
  logic [WORD_W-1:0]         cnt_q;
  logic [N_HARTS*WORD_W-1:0] cmp_flat;
  logic [WORD_W-1:0]         cmp_sel;
  logic [WORD_W-1:0]         rd_next;
  logic [WORD_W-1:0]         rdata_q;

  ht_decode #(
    .N_HARTS (N_HARTS),
    .ADDR_W  (ADDR_W),
    .CMP_BASE(CMP_BASE),
    .CNT_BASE(CNT_BASE),
    .SLOT_W  (SLOT_W)
  ) u_dec (
    .addr   (bus_addr),
    .wide   (bus_wide),
    .cnt_hit(cnt_hit),
    .cmp_hit(cmp_hit),
    .slot   (slot),
    .kind   (kind)
  );

  assign cnt_wk = (bus_we && cnt_hit) ? kind : ACC_NONE;
  assign cmp_wk = (bus_we && cmp_hit) ? kind : ACC_NONE;

  ht_counter #(
    .CNT_W(WORD_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .wr_kind(cnt_wk),
    .wdata  (bus_wdata),
    .cnt_o  (cnt_q)
  );

  ht_cmp_bank #(
    .N_HARTS(N_HARTS),
    .SLOT_W (SLOT_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_kind   (cmp_wk),
    .wr_slot   (slot),
    .wdata     (bus_wdata),
    .cnt_i     (cnt_q),
    .cmp_flat_o(cmp_flat),
    .irq_o     (irq_o)
  );

  always_comb begin
    cmp_sel = '0;
    for (int i = 0; i < N_HARTS; i++) begin
      if (slot == SLOT_W'(i)) cmp_sel = cmp_flat[i*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    if (cnt_hit)      rd_next = read_view(cnt_q, kind);
    else if (cmp_hit) rd_next = read_view(cmp_sel, kind);
    else              rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk #(
  parameter int N_HARTS  = 4,
  parameter int ADDR_W   = 12,
  parameter int CNT_BASE = 'h40
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick_en,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wide,
  input logic                   bus_we,
  input logic [63:0]            bus_wdata,
  input logic [63:0]            cnt,
  input logic [N_HARTS*64-1:0]  cmp_flat,
  input logic [N_HARTS-1:0]     irq
);

  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HA = ADDR_W'(CNT_BASE + 4);

  logic cnt_wr;
  logic rst_d = 1'b0;

  assign cnt_wr = bus_we && ((bus_addr == CNT_A) || ((bus_addr == CNT_HA) && !bus_wide));

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      // R1
      rst_clear_chk: assert (cnt == '0 && irq == '0)
        else $error("R1 counter or interrupt not cleared by reset");
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_wr) |=> $stable(cnt));

  // R3
  cnt_wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wide && bus_addr == CNT_A) |=> (cnt == $past(bus_wdata)));

  // R5
  wide_hi_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wide && bus_addr == CNT_HA && !tick_en) |=> $stable(cnt));

  for (genvar i = 0; i < N_HARTS; i++) begin : g_irq
    // R8
    irq_cmp_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq[i] == ($past(cmp_flat[i*64 +: 64]) <= $past(cnt))));
  end

endmodule

bind hart_timer hart_timer_chk #(
  .N_HARTS (N_HARTS),
  .ADDR_W  (ADDR_W),
  .CNT_BASE(CNT_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .bus_addr (bus_addr),
  .bus_wide (bus_wide),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .cnt      (cnt_q),
  .cmp_flat (cmp_flat),
  .irq      (irq_o)
);

// File: tb/sim_hart_timer.sv
`timescale 1ns/1ps
module sim_hart_timer;

  localparam int NH  = 4;
  localparam int AW  = 12;
  localparam int CNT = 'h40;

  logic          clk = 1'b0;
  logic          rst;
  logic          tick_en;
  logic [AW-1:0] bus_addr;
  logic          bus_wide;
  logic          bus_we;
  logic [63:0]   bus_wdata;
  logic [63:0]   bus_rdata;
  logic [NH-1:0] irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] mcmp [NH];
  logic [63:0] mcnt;

  always #4 clk = ~clk;

  hart_timer #(
    .N_HARTS (NH),
    .ADDR_W  (AW),
    .CMP_BASE(0),
    .CNT_BASE(CNT)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_wide (bus_wide),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input bit wide, input logic [63:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wide = wide; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, input bit wide, output logic [63:0] data);
    @(negedge clk);
    bus_addr = AW'(addr); bus_wide = wide; bus_we = 1'b0;
    @(negedge clk);
    data = bus_rdata;
  endtask

  function automatic logic [NH-1:0] exp_irq();
    logic [NH-1:0] e;
    for (int i = 0; i < NH; i++) e[i] = (mcmp[i] <= mcnt);
    return e;
  endfunction

  task automatic chk_regs(input string tag);
    logic [63:0] v;
    for (int h = 0; h < NH; h++) begin
      rd(8*h, 1'b1, v);
      chk(tag, v, mcmp[h]);
    end
    rd(CNT, 1'b1, v);
    chk(tag, v, mcnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    rst = 1'b1; tick_en = 1'b0; bus_addr = '0; bus_wide = 1'b0;
    bus_we = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    mcnt = 64'd0;
    for (int h = 0; h < NH; h++) mcmp[h] = '1;

    // R1 reset state
    chk("R1 irq after reset", 64'(irq_o), 64'd0);
    rd(CNT, 1'b1, v);
    chk("R1 counter after reset", v, 64'd0);
    rd(0, 1'b1, v);
    chk("R1 compare after reset", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 R5 R6 full writes per slot, read back in three shapes
    for (int h = 0; h < NH; h++) begin
      mcmp[h] = {32'(h + 1) * 32'h0101_0101, 32'hA5A5_0000 + 32'(h)};
      wr(8*h, 1'b1, mcmp[h]);
    end
    for (int h = 0; h < NH; h++) begin
      rd(8*h, 1'b1, v);     chk("R7 R5 full readback", v, mcmp[h]);
      rd(8*h, 1'b0, v);     chk("R6 low half read", v, {32'd0, mcmp[h][31:0]});
      rd(8*h + 4, 1'b0, v); chk("R6 high half read", v, {32'd0, mcmp[h][63:32]});
    end

    // R5 64-bit write at offset 4 ignored
    wr(8 + 4, 1'b1, 64'h0);
    wr(CNT + 4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_regs("R5 wide write at offset 4");

    // R4 half-word merges on a compare and on the counter
    wr(16, 1'b0, 64'hDEAD_BEEF_1234_5678);
    mcmp[2][31:0] = 32'h1234_5678;
    rd(16, 1'b1, v); chk("R4 compare low merge", v, mcmp[2]);
    wr(16 + 4, 1'b0, 64'hFFFF_FFFF_9ABC_DEF0);
    mcmp[2][63:32] = 32'h9ABC_DEF0;
    rd(16, 1'b1, v); chk("R4 compare high merge", v, mcmp[2]);
    wr(CNT + 4, 1'b0, 64'h0000_0000_0000_0003);
    mcnt[63:32] = 32'h3;
    wr(CNT, 1'b0, 64'h7777_7777_0000_0009);
    mcnt[31:0] = 32'h9;
    rd(CNT, 1'b1, v); chk("R4 counter half merges", v, mcnt);

    // R10 unmapped, invalid slots, misaligned and wide-at-4 reads
    for (int a = 'h20; a < 'h40; a += 4) begin
      rd(a, 1'b0, v); chk("R10 invalid slot read", v, 64'd0);
    end
    rd('h48, 1'b0, v);     chk("R10 unmapped read", v, 64'd0);
    rd('h01, 1'b0, v);     chk("R10 misaligned read", v, 64'd0);
    rd(CNT + 4, 1'b1, v);  chk("R10 wide read at offset 4", v, 64'd0);
    rd(4, 1'b1, v);        chk("R10 wide compare read at offset 4", v, 64'd0);
    wr('h20, 1'b1, 64'h0);
    wr('h01, 1'b0, 64'h0);
    wr(CNT + 1, 1'b0, 64'h0);
    wr('h48, 1'b1, 64'h0);
    chk_regs("R10 stray writes");

    // R2 ticking with carry across the halves, then hold
    wr(CNT, 1'b1, 64'h0000_0000_FFFF_FFFE);
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    mcnt = 64'h0000_0001_0000_0003;
    rd(CNT, 1'b1, v); chk("R2 count with carry", v, mcnt);
    repeat (6) @(negedge clk);
    rd(CNT, 1'b1, v); chk("R2 hold without tick", v, mcnt);

    // R3 write and tick in the same cycle
    @(negedge clk);
    tick_en = 1'b1;
    bus_addr = AW'(CNT); bus_wide = 1'b1; bus_wdata = 64'h0123_4567_89AB_CDEF; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    mcnt = 64'h0123_4567_89AB_CDEF;
    rd(CNT, 1'b1, v); chk("R3 write beats tick", v, mcnt);

    // R8 compares around the count
    mcnt = 64'h0000_0001_0000_0005;
    wr(CNT, 1'b1, mcnt);
    mcmp[0] = mcnt - 1; mcmp[1] = mcnt; mcmp[2] = mcnt + 1;
    mcmp[3] = 64'h0000_0002_0000_0000;
    for (int h = 0; h < NH; h++) wr(8*h, 1'b1, mcmp[h]);
    @(negedge clk);
    chk("R8 below equal above", 64'(irq_o), 64'(exp_irq()));
    mcmp[3] = 64'h0000_0000_FFFF_FFFF;
    wr(24, 1'b1, mcmp[3]);
    @(negedge clk);
    chk("R8 high half decides", 64'(irq_o), 64'(exp_irq()));
    mcnt = 64'h0000_0000_FFFF_FFFF;
    mcmp[2] = 64'h0000_0001_0000_0000;
    wr(16, 1'b1, mcmp[2]);
    wr(CNT, 1'b1, mcnt);
    @(negedge clk);
    chk("R8 32-bit boundary", 64'(irq_o), 64'(exp_irq()));

    // R9 counter write moves all harts on the next cycle
    mcnt = 64'hFFFF_0000_0000_0000;
    wr(CNT, 1'b1, mcnt);
    chk("R9 irq not yet updated", 64'(irq_o), 64'b1000);
    @(negedge clk);
    chk("R9 all harts raised", 64'(irq_o), 64'(exp_irq()));
    mcnt = 64'd0;
    wr(CNT, 1'b1, mcnt);
    chk("R9 irq still high", 64'(irq_o), 64'b1111);
    @(negedge clk);
    chk("R9 all harts dropped", 64'(irq_o), 64'(exp_irq()));

    // R8 per-hart walk with one-cycle latency
    for (int h = 0; h < NH; h++) mcmp[h] = '1;
    for (int h = 0; h < NH; h++) wr(8*h, 1'b1, mcmp[h]);
    for (int h = 0; h < NH; h++) begin
      mcmp[h] = 64'd0;
      wr(8*h, 1'b1, 64'd0);
      chk("R8 latency before", 64'(irq_o), 64'd0);
      @(negedge clk);
      chk("R8 single hart raised", 64'(irq_o), 64'(exp_irq()));
      mcmp[h] = '1;
      wr(8*h, 1'b1, mcmp[h]);
      @(negedge clk);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule